// File: doc/BRIEF.md
# Serial Result Readout Port

This block sits between a conversion sequencer and a three-wire, externally clocked serial port. When the sequencer finishes a full conversion cycle it presents a 20-bit result and pulses a load strobe. The block captures the word, drives an active-low data-ready flag, and waits for a host to pull chip select low. The host then clocks the word out, most significant bit first. Each new bit appears after a falling serial clock edge, and the shifter moves only after it has seen one rising edge in the current session.

Chip select, serial clock and the load strobe pass through two-flop synchronisers into the core clock domain, and both serial clock edges are detected there. If the host releases chip select partway through a word, the block finishes the bit it is driving and then floats the data pin. The word stays pending, and the next session starts again from the most significant bit. Chip select is not recognised while data-ready is inactive. The data pin is high-impedance whenever no session is running.

Top module: `readout_port`

## Requirements
- R1: After reset, data-ready (`drdy_n_o`, active low) is 1 and `sdata_o` is high-impedance ('z).
- R2: A rising edge on `res_load_i` captures `res_word_i` and drives `drdy_n_o` to 0 on the fourth core clock edge after the strobe rises. `res_word_i` must stay stable until then.
- R3: During a session, `sdata_o` first shows bit 19 of the captured word. Each qualifying falling `sclk_i` edge then advances the line to the next lower bit, so that 20 bits are sent MSB first.
- R4: A falling `sclk_i` edge does not advance the shifter until a rising `sclk_i` edge has been seen within the current session. A rising edge seen before the session began does not count.
- R5: While `drdy_n_o` is 1, pulling `cs_n_i` low starts no session, and `sdata_o` stays 'z.
- R6: The 20th qualifying falling edge ends the session. `drdy_n_o` returns to 1 and `sdata_o` becomes 'z.
- R7: If `cs_n_i` rises after the first rising `sclk_i` edge of a session, the current bit stays driven until the next falling `sclk_i` edge and then `sdata_o` floats. `drdy_n_o` stays 0, and the next session restarts at bit 19.
- R8: If `cs_n_i` rises before any rising `sclk_i` edge of a session, `sdata_o` floats at once and `drdy_n_o` stays 0.
- R9: A load that arrives while `drdy_n_o` is 0 ends any session. It drives `drdy_n_o` to 1 for exactly one core cycle (the third edge after the strobe), then to 0 with the new word.
- R10: A change on `cs_n_i` or `sclk_i` takes effect on the third core clock edge after it. Starting a session, `sdata_o` is still 'z after two edges and shows bit 19 after three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_word_i | input | 20 | Conversion result from the sequencer |
| res_load_i | input | 1 | Load strobe; its rising edge captures the result |
| cs_n_i | input | 1 | Chip select from host, active low |
| sclk_i | input | 1 | Serial clock from host |
| sdata_o | output | 1 | Serial data, high-impedance when idle |
| drdy_n_o | output | 1 | Data-ready flag, active low |

## Verification
Each serial-side input is registered through two synchroniser flops, and an edge is acted on at the third core edge. The data pin therefore moves three edges after a chip-select or serial-clock change, and data-ready moves three or four edges after a load. The bench drives inputs one time unit after a core edge and samples at the same offset. The exact latency is checked at three and four edges. Every other check waits four core cycles after its stimulus, and the serial clock half-period is four core cycles, so each sample falls inside a settled window.

// File: rtl/rrp_pkg.sv
package rrp_pkg;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_SHIFT = 2'd1,
    RD_DRAIN = 2'd2
  } rd_state_e;

  // True when the bit index points at the final bit of the word.
  function automatic logic at_final_bit(input int unsigned idx, input int unsigned width);
    return idx == width - 1;
  endfunction

  // Next bit index while shifting.
  function automatic int unsigned step_index(input int unsigned idx);
    return idx + 1;
  endfunction

endpackage

// File: rtl/rrp_sync.sv
module rrp_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rrp_edge.sv
module rrp_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/rrp_shifter.sv
module rrp_shifter
  import rrp_pkg::*;
#(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture_i,
  input  logic [W-1:0] word_i,
  input  logic         restart_i,
  input  logic         advance_i,
  output logic         msb_o,
  output logic         last_o
);
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]     held_q;
  logic [W-1:0]     shreg_q;
  logic [CNT_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= '0;
      shreg_q <= '0;
      idx_q   <= '0;
    end else if (capture_i) begin
      held_q  <= word_i;
      shreg_q <= word_i;
      idx_q   <= '0;
    end else if (restart_i) begin
      shreg_q <= held_q;
      idx_q   <= '0;
    end else if (advance_i) begin
      shreg_q <= {shreg_q[W-2:0], 1'b0};
      idx_q   <= CNT_W'(step_index(int'(idx_q)));
    end
  end

  assign msb_o  = shreg_q[W-1];
  assign last_o = at_final_bit(int'(idx_q), W);

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < W);

  // R3
  restart_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && !capture_i) |=> (msb_o == held_q[W-1]));
endmodule

// File: rtl/readout_port.sv
module readout_port
  import rrp_pkg::*;
#(
  parameter int unsigned WORD_W = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] res_word_i,
  input  logic              res_load_i,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  output logic              sdata_o,
  output logic              drdy_n_o
);
  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] raw_in, synced;
  logic cs_s, sclk_s, ld_s;

  assign raw_in = {res_load_i, sclk_i, cs_n_i};

  rrp_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(synced)
  );

  assign cs_s   = synced[0];
  assign sclk_s = synced[1];
  assign ld_s   = synced[2];

  logic sclk_rise, sclk_fall, ld_rise, ld_fall_unused;

  rrp_edge #(.RST_VAL(1'b0)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(sclk_s), .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  rrp_edge #(.RST_VAL(1'b0)) u_ld_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(ld_s), .rise_o(ld_rise), .fall_o(ld_fall_unused)
  );

  rd_state_e st_q;
  logic      drdy_n_q;
  logic      armed_q;
  logic      upd_q;
  logic      bit_msb, bit_last;

  // Named internal events
  logic start_evt, step_evt, done_evt, driving;

  assign start_evt = (st_q == RD_IDLE) && !cs_s && !drdy_n_q && !ld_rise && !upd_q;
  assign step_evt  = (st_q == RD_SHIFT) && sclk_fall && armed_q && !ld_rise;
  assign done_evt  = step_evt && bit_last;
  assign driving   = (st_q != RD_IDLE);

  rrp_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .capture_i(upd_q), .word_i(res_word_i),
    .restart_i(start_evt),
    .advance_i(step_evt && !bit_last),
    .msb_o(bit_msb), .last_o(bit_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= RD_IDLE;
      drdy_n_q <= 1'b1;
      armed_q  <= 1'b0;
      upd_q    <= 1'b0;
    end else begin
      upd_q <= ld_rise;
      if (ld_rise) begin
        drdy_n_q <= 1'b1;
        st_q     <= RD_IDLE;
        armed_q  <= 1'b0;
      end else if (upd_q) begin
        drdy_n_q <= 1'b0;
      end else begin
        unique case (st_q)
          RD_IDLE: begin
            if (start_evt) begin
              st_q    <= RD_SHIFT;
              armed_q <= 1'b0;
            end
          end
          RD_SHIFT: begin
            if (step_evt) begin
              if (bit_last) begin
                st_q     <= RD_IDLE;
                drdy_n_q <= 1'b1;
              end else if (cs_s) begin
                st_q <= RD_IDLE;
              end
            end else if (sclk_rise) begin
              armed_q <= 1'b1;
            end else if (cs_s) begin
              st_q <= armed_q ? RD_DRAIN : RD_IDLE;
            end
          end
          RD_DRAIN: begin
            if (sclk_fall) st_q <= RD_IDLE;
          end
          default: st_q <= RD_IDLE;
        endcase
      end
    end
  end

  assign sdata_o  = driving ? bit_msb : 1'bz;
  assign drdy_n_o = drdy_n_q;

  // R5
  cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(driving) |-> !drdy_n_q);

  // R6
  done_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (st_q == RD_IDLE) && drdy_n_q);

  // R6
  drive_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    driving |-> !drdy_n_q);

  // R4
  unarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == RD_SHIFT) && !armed_q) |=> $stable(bit_msb));

  // R7
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RD_DRAIN) |=> $stable(bit_msb));

  // R2
  ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n_q) |-> $past(ld_rise, 2));
endmodule

// File: tb/readout_port_test.sv
module readout_port_test;
  localparam int W = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] word = '0;
  logic         load = 1'b0;
  logic         cs_n = 1'b1;
  logic         sclk = 1'b0;
  logic         sdata;
  logic         drdy_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  readout_port uut (
    .clk(clk), .rst_n(rst_n), .res_word_i(word), .res_load_i(load),
    .cs_n_i(cs_n), .sclk_i(sclk), .sdata_o(sdata), .drdy_n_o(drdy_n)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_z(input string req);
    check(req, {31'b0, sdata}, {31'b0, 1'bz});
  endtask

  task automatic chk_bit(input string req, input logic b);
    check(req, {31'b0, sdata}, {31'b0, b});
  endtask

  // R2 / R9: drdy high at third edge, low at fourth
  task automatic do_load(input logic [W-1:0] w);
    word = w;
    load = 1'b1;
    wait_cyc(3);
    check("R9 drdy high before update", {31'b0, drdy_n}, 32'd1);
    wait_cyc(1);
    check("R2 drdy low after capture", {31'b0, drdy_n}, 32'd0);
    load = 1'b0;
    wait_cyc(2);
  endtask

  task automatic shift_bits(input logic [W-1:0] w, input int from_bit, input int n);
    for (int k = 0; k < n; k++) begin
      chk_bit("R3 bit value", w[from_bit - k]);
      sclk = 1'b1; wait_cyc(4);
      sclk = 1'b0; wait_cyc(4);
    end
  endtask

  task automatic full_read(input logic [W-1:0] w);
    cs_n = 1'b0;
    wait_cyc(2);
    chk_z("R10 not yet driven");
    wait_cyc(1);
    chk_bit("R10 msb after three edges", w[W-1]);
    wait_cyc(1);
    shift_bits(w, W-1, W);
    check("R6 drdy back high", {31'b0, drdy_n}, 32'd1);
    chk_z("R6 floats after word");
    cs_n = 1'b1;
    wait_cyc(4);
  endtask

  initial begin
    wait_cyc(5);
    check("R1 drdy reset", {31'b0, drdy_n}, 32'd1);
    chk_z("R1 sdata reset");
    rst_n = 1'b1;
    wait_cyc(3);

    // R5: chip select ignored while not ready
    cs_n = 1'b0; wait_cyc(4);
    chk_z("R5 cs ignored");
    sclk = 1'b1; wait_cyc(4); sclk = 1'b0; wait_cyc(4);
    chk_z("R5 still floating");
    cs_n = 1'b1; wait_cyc(4);

    // R3 sweep: walking ones then fixed and arithmetic patterns
    for (int i = 0; i < 28; i++) begin
      logic [W-1:0] w;
      if (i < W) w = W'(1) << i;
      else w = W'((i * 32'h1D3B7) ^ (32'hAAAAA >> (i - W)));
      if (i == 26) w = '1;
      if (i == 27) w = '0;
      do_load(w);
      full_read(w);
    end
    cs_n = 1'b0; wait_cyc(4);
    chk_z("R5 ignored after complete readout");
    cs_n = 1'b1; wait_cyc(4);

    // R4 + R7: rising edge before session does not arm; release mid-word
    begin
      logic [W-1:0] w = 20'hB2C39;
      do_load(w);
      sclk = 1'b1; wait_cyc(4);
      cs_n = 1'b0; wait_cyc(4);
      chk_bit("R4 msb at start", w[19]);
      sclk = 1'b0; wait_cyc(4);
      chk_bit("R4 unarmed fall no shift", w[19]);
      sclk = 1'b1; wait_cyc(4);
      sclk = 1'b0; wait_cyc(4);
      chk_bit("R4 shift after rise", w[18]);
      sclk = 1'b1; wait_cyc(4);
      cs_n = 1'b1; wait_cyc(4);
      chk_bit("R7 bit held after release", w[18]);
      sclk = 1'b0; wait_cyc(4);
      chk_z("R7 floats after bit");
      check("R7 drdy stays low", {31'b0, drdy_n}, 32'd0);
      full_read(w);
    end

    // R8: release before any rising edge
    begin
      logic [W-1:0] w = 20'h4E71D;
      do_load(w);
      cs_n = 1'b0; wait_cyc(4);
      chk_bit("R8 msb driven", w[19]);
      cs_n = 1'b1; wait_cyc(4);
      chk_z("R8 floats at once");
      check("R8 drdy stays low", {31'b0, drdy_n}, 32'd0);
      full_read(w);
    end

    // R9: new load mid-session aborts and restarts with new word
    begin
      logic [W-1:0] w1 = 20'h3C0F5;
      logic [W-1:0] w2 = 20'hC3F0A;
      do_load(w1);
      cs_n = 1'b0; wait_cyc(4);
      shift_bits(w1, W-1, 3);
      word = w2;
      load = 1'b1;
      wait_cyc(3);
      check("R9 drdy pulse high", {31'b0, drdy_n}, 32'd1);
      chk_z("R9 session aborted");
      wait_cyc(1);
      check("R9 drdy low with new word", {31'b0, drdy_n}, 32'd0);
      load = 1'b0;
      wait_cyc(2);
      chk_bit("R9 new msb", w2[W-1]);
      shift_bits(w2, W-1, W);
      check("R9 drdy high after new word", {31'b0, drdy_n}, 32'd1);
      cs_n = 1'b1; wait_cyc(4);
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule